// File: doc/BRIEF.md
# Fused Single-Precision Dot-Product Unit

This block evaluates A*B + C*D on four IEEE-754 single-precision operands and rounds the result only once. Each product is formed exactly at 48 bits. The unit compares the two product exponents and shifts the smaller product right to line up with the larger one. Bits that fall off the end are folded into a sticky bit. The two products are then added, or subtracted when their signs differ. The sum passes through one shared path that counts leading zeros, renormalises, and rounds to nearest even. Discrete hardware rounds three times: once for each multiply and once for the add.

Operands arrive through a valid/ready handshake. A small controller has two states. In `ST_IDLE` it accepts one operand set (transition `accept`). The next cycle is spent in `ST_EXEC`, where the combinational datapath works on the latched operands. The controller then returns to `ST_IDLE` (transition `finish`) and loads the result register. It raises `out_valid` for exactly one cycle, together with an inexact flag.

When B is exactly 1.0, a forwarding multiplexer routes A around its multiplier. D and C are handled the same way. With B and D both 1.0 the unit acts as a single-rounding adder of A and C. Subnormal inputs are read as zero. Every NaN result is the canonical quiet NaN.

Top module: `fdp_top`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` and `out_inexact` are 0, `out_result` is 0x00000000 and `in_ready` is 1.
- R2: An operand set is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for the following cycle. The result appears, with `out_valid` high, for one cycle only, after the second edge following acceptance. `out_result` does not change while `out_valid` is low.
- R3: For normal operands, `out_result` equals the exact value of A*B + C*D rounded once to single precision.
- R4: When the product signs differ, the smaller product magnitude is subtracted and the result takes the sign of the larger product (1*2 + (-1)*3 gives 0xBF800000).
- R5: A sum that cancels exactly gives +0 (0x00000000) with `out_inexact` 0.
- R6: Rounding is to nearest, with ties going to the even significand (1.0000001192 * 1.5 gives 0x3FC00002).
- R7: `out_inexact` is 1 exactly when the rounded result differs from the exact value. Example: 2*3 + 1*1 gives 0x40E00000 with the flag at 0.
- R8: A rounded exponent above 254 gives a signed infinity (exponent field 0xFF, fraction 0) with `out_inexact` 1.
- R9: A rounded biased exponent of 0 or below gives a zero carrying the sum's sign, with `out_inexact` 1. No subnormal result is ever produced.
- R10: A NaN operand, an infinity times a zero, or two infinite products of opposite sign gives 0x7FC00000 with `out_inexact` 0.
- R11: An infinite product with no NaN condition gives an infinity of that product's sign, with `out_inexact` 0.
- R12: An operand with exponent field 0 counts as zero, whatever its fraction holds.
- R13: With B and D equal to 1.0 (0x3F800000), the result is A + C rounded once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Unit can take an operand set |
| op_a | input | 32 | Operand A, single precision |
| op_b | input | 32 | Operand B, single precision |
| op_c | input | 32 | Operand C, single precision |
| op_d | input | 32 | Operand D, single precision |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 32 | Rounded A*B + C*D |
| out_inexact | output | 1 | Result was rounded |

## Verification
Two things can happen in the same cycle: the one-cycle result strobe, and acceptance of the next operand set. Both fall in the first `ST_IDLE` cycle after `ST_EXEC`. The bench drives transactions back to back with `in_valid` held high, so each new set is taken exactly while the previous result is on the outputs. A scoreboard queue pairs each strobe with the operand set that produced it. If the overlap loses, duplicates or misorders a result, the comparison fails. The protocol assertions also check the ready drop and the strobe timing on every accepted set.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;
    localparam int WORD_W = EXP_W + FRAC_W + 1;
    localparam int MANT_W = FRAC_W + 1;
    localparam int PROD_W = 2 * MANT_W;
    localparam int GRD_W  = 3;
    localparam int SUM_W  = PROD_W + GRD_W + 1;
    localparam int SH_W   = $clog2(SUM_W + 1);
    localparam int XE_W   = EXP_W + 4;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] man;
        logic              zero;
        logic              inf;
        logic              nan;
    } fp_op_t;

    typedef struct packed {
        logic                   sgn;
        logic signed [XE_W-1:0] exp;
        logic [PROD_W-1:0]      man;
        logic                   zero;
    } fp_term_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } fdp_state_e;
endpackage

// File: rtl/fdp_unpack.sv
module fdp_unpack
    import fdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_op_t            op
);
    logic [EXP_W-1:0]  e_fld;
    logic [FRAC_W-1:0] f_fld;

    always_comb begin
        e_fld   = word[WORD_W-2 -: EXP_W];
        f_fld   = word[FRAC_W-1:0];
        op.sgn  = word[WORD_W-1];
        op.exp  = e_fld;
        op.zero = (e_fld == '0);
        op.inf  = (e_fld == {EXP_W{1'b1}}) && (f_fld == '0);
        op.nan  = (e_fld == {EXP_W{1'b1}}) && (f_fld != '0);
        op.man  = op.zero ? '0 : {1'b1, f_fld};
    end
endmodule

// File: rtl/fdp_mul.sv
module fdp_mul
    import fdp_pkg::*;
(
    input  fp_op_t   x,
    input  fp_op_t   y,
    output fp_term_t term,
    output logic     is_inf,
    output logic     is_nan
);
    logic                   y_unit;
    logic [PROD_W-1:0]      tree;
    logic [PROD_W-1:0]      raw;
    logic signed [XE_W-1:0] esum;

    always_comb begin
        y_unit = (y.exp == EXP_W'(BIAS)) && (y.man == {1'b1, {FRAC_W{1'b0}}});
        tree   = PROD_W'(x.man) * PROD_W'(y.man);
        raw    = y_unit ? {1'b0, x.man, {(MANT_W-1){1'b0}}} : tree;
        esum   = $signed({{(XE_W-EXP_W){1'b0}}, x.exp})
               + $signed({{(XE_W-EXP_W){1'b0}}, y.exp})
               - XE_W'(BIAS);

        is_nan = x.nan || y.nan || (x.inf && y.zero) || (x.zero && y.inf);
        is_inf = (x.inf || y.inf) && !is_nan;

        term.sgn  = x.sgn ^ y.sgn;
        term.zero = (x.zero || y.zero) && !is_nan;
        if (raw[PROD_W-1]) begin
            term.man = raw;
            term.exp = esum + XE_W'(1);
        end else begin
            term.man = raw << 1;
            term.exp = esum;
        end
    end
endmodule

// File: rtl/fdp_align_add.sv
module fdp_align_add
    import fdp_pkg::*;
(
    input  fp_term_t               t0,
    input  fp_term_t               t1,
    output logic [SUM_W-1:0]       sum,
    output logic signed [XE_W-1:0] exp_big,
    output logic                   sgn_big
);
    logic                   pick1;
    fp_term_t               big;
    fp_term_t               sml;
    logic signed [XE_W-1:0] diff;
    logic [SH_W-1:0]        sh;
    logic [SUM_W-1:0]       ext_big;
    logic [SUM_W-1:0]       ext_sml;
    logic [SUM_W-1:0]       shifted;
    logic                   sticky;
    logic [SUM_W-1:0]       aligned;

    always_comb begin
        if (t0.zero)      pick1 = 1'b1;
        else if (t1.zero) pick1 = 1'b0;
        else              pick1 = (t1.exp > t0.exp) ||
                                  ((t1.exp == t0.exp) && (t1.man > t0.man));
        big = pick1 ? t1 : t0;
        sml = pick1 ? t0 : t1;

        diff = big.exp - sml.exp;
        if (diff >= XE_W'(SUM_W)) sh = SH_W'(SUM_W);
        else                      sh = diff[SH_W-1:0];

        ext_big = {1'b0, big.man, {GRD_W{1'b0}}};
        ext_sml = sml.zero ? '0 : {1'b0, sml.man, {GRD_W{1'b0}}};
        shifted = ext_sml >> sh;
        sticky  = |(ext_sml & ~({SUM_W{1'b1}} << sh));
        aligned = shifted | {{(SUM_W-1){1'b0}}, sticky};

        if (big.sgn ^ sml.sgn) sum = ext_big - aligned;
        else                   sum = ext_big + aligned;
        exp_big = big.exp;
        sgn_big = big.sgn;
    end
endmodule

// File: rtl/fdp_norm_round.sv
module fdp_norm_round
    import fdp_pkg::*;
(
    input  logic [SUM_W-1:0]       sum,
    input  logic signed [XE_W-1:0] exp_big,
    input  logic                   sgn,
    output logic [WORD_W-1:0]      word,
    output logic                   inexact
);
    logic [SH_W-1:0]        lz;
    logic [SUM_W-1:0]       norm;
    logic signed [XE_W-1:0] er;
    logic signed [XE_W-1:0] er_f;
    logic [MANT_W-1:0]      kept;
    logic                   guard;
    logic                   sticky;
    logic                   rnd_up;
    logic [MANT_W:0]        rounded;
    logic [FRAC_W-1:0]      frac_f;

    function automatic logic [SH_W-1:0] count_lz(input logic [SUM_W-1:0] v);
        logic [SH_W-1:0] n;
        n = SH_W'(SUM_W);
        for (int i = 0; i < SUM_W; i++) begin
            if (v[i]) n = SH_W'(SUM_W - 1 - i);
        end
        return n;
    endfunction

    always_comb begin
        lz      = count_lz(sum);
        norm    = sum << lz;
        er      = exp_big + XE_W'(1) - XE_W'(lz);
        kept    = norm[SUM_W-1 -: MANT_W];
        guard   = norm[SUM_W-1-MANT_W];
        sticky  = |norm[SUM_W-2-MANT_W:0];
        rnd_up  = guard && (sticky || kept[0]);
        rounded = {1'b0, kept} + (MANT_W+1)'(rnd_up);
        if (rounded[MANT_W]) begin
            frac_f = rounded[FRAC_W:1];
            er_f   = er + XE_W'(1);
        end else begin
            frac_f = rounded[FRAC_W-1:0];
            er_f   = er;
        end

        if (sum == '0) begin
            word    = '0;
            inexact = 1'b0;
        end else if (er_f >= XE_W'(EMAX)) begin
            word    = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            inexact = 1'b1;
        end else if (er_f <= XE_W'(0)) begin
            word    = {sgn, {(WORD_W-1){1'b0}}};
            inexact = 1'b1;
        end else begin
            word    = {sgn, er_f[EXP_W-1:0], frac_f};
            inexact = guard || sticky;
        end
    end
endmodule

// File: rtl/fdp_top.sv
module fdp_top
    import fdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_c,
    input  logic [WORD_W-1:0] op_d,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_inexact
);
    localparam int N_OPS  = 4;
    localparam int N_PROD = N_OPS / 2;

    fdp_state_e state_q, state_d;
    logic       accept;
    logic       finish;

    logic [WORD_W-1:0] opnd_q [N_OPS];
    fp_op_t            unp    [N_OPS];
    fp_term_t          terms  [N_PROD];
    logic              t_inf  [N_PROD];
    logic              t_nan  [N_PROD];

    logic [SUM_W-1:0]       sum;
    logic signed [XE_W-1:0] exp_big;
    logic                   sgn_big;
    logic [WORD_W-1:0]      nr_word;
    logic                   nr_inexact;
    logic [WORD_W-1:0]      res_d;
    logic                   inx_d;

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // controller: next state and handshake outputs
    always_comb begin
        state_d  = state_q;
        in_ready = 1'b0;
        accept   = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    accept  = 1'b1;
                    state_d = ST_EXEC;
                end
            end
            ST_EXEC: begin
                finish  = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    // operand capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_OPS; i++) opnd_q[i] <= '0;
        end else if (accept) begin
            opnd_q[0] <= op_a;
            opnd_q[1] <= op_b;
            opnd_q[2] <= op_c;
            opnd_q[3] <= op_d;
        end
    end

    generate
        for (genvar gi = 0; gi < N_OPS; gi++) begin : g_unpack
            fdp_unpack u_unpack (
                .word (opnd_q[gi]),
                .op   (unp[gi])
            );
        end
        for (genvar gp = 0; gp < N_PROD; gp++) begin : g_mul
            fdp_mul u_mul (
                .x      (unp[2*gp]),
                .y      (unp[2*gp+1]),
                .term   (terms[gp]),
                .is_inf (t_inf[gp]),
                .is_nan (t_nan[gp])
            );
        end
    endgenerate

    fdp_align_add u_align_add (
        .t0      (terms[0]),
        .t1      (terms[1]),
        .sum     (sum),
        .exp_big (exp_big),
        .sgn_big (sgn_big)
    );

    fdp_norm_round u_norm_round (
        .sum     (sum),
        .exp_big (exp_big),
        .sgn     (sgn_big),
        .word    (nr_word),
        .inexact (nr_inexact)
    );

    // special-value override ahead of the result register
    always_comb begin
        res_d = nr_word;
        inx_d = nr_inexact;
        if (t_nan[0] || t_nan[1] ||
            (t_inf[0] && t_inf[1] && (terms[0].sgn != terms[1].sgn))) begin
            res_d = QNAN_WORD;
            inx_d = 1'b0;
        end else if (t_inf[0] || t_inf[1]) begin
            res_d = {t_inf[0] ? terms[0].sgn : terms[1].sgn,
                     {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            inx_d = 1'b0;
        end
    end

    // registered result port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= finish;
            if (finish) begin
                out_result  <= res_d;
                out_inexact <= inx_d;
            end
        end
    end
endmodule

// File: rtl/fdp_chk.sv
module fdp_chk
    import fdp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_result,
    input logic              out_inexact
);
    logic res_is_nan;
    assign res_is_nan = (out_result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}}) &&
                        (out_result[FRAC_W-1:0] != '0);

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready); // R2
    AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |-> ##2 out_valid); // R2
    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R2
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_result)); // R2
    AST_CANON_NAN: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && res_is_nan) |-> (out_result == QNAN_WORD)); // R10
    AST_NAN_EXACT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && res_is_nan) |-> !out_inexact); // R10
    AST_NO_DENORM: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !((out_result[WORD_W-2 -: EXP_W] == '0) && (out_result[FRAC_W-1:0] != '0))); // R9
endmodule

bind fdp_top fdp_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_inexact (out_inexact)
);

// File: tb/fdp_top_tb.sv
module fdp_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_inexact;

    typedef struct {
        logic [31:0] bits;
        logic        inex;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_pushed = 0;
    int   n_seen = 0;
    int   cyc = 0;
    logic prev_acc = 1'b0;

    always #10 clk = ~clk;

    fdp_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .out_valid(out_valid), .out_result(out_result), .out_inexact(out_inexact)
    );

    function automatic real to_real(input logic [31:0] w);
        logic [10:0] e;
        if (w[30:23] == 8'h00) return 0.0;
        e = 11'(w[30:23]) - 11'd127 + 11'd1023;
        return $bitstoreal({w[31], e, w[22:0], 29'b0});
    endfunction

    function automatic logic [32:0] to_single(input real r);
        logic [63:0] b;
        logic [52:0] m;
        logic [24:0] k;
        logic        g, st;
        int          e;
        if (r == 0.0) return 33'd0;
        b  = $realtobits(r);
        e  = int'(b[62:52]) - 1023 + 127;
        m  = {1'b1, b[51:0]};
        g  = m[28];
        st = |m[27:0];
        k  = {1'b0, m[52:29]} + 25'((g && (st || m[29])) ? 1 : 0);
        if (k[24]) begin
            e = e + 1;
            k = k >> 1;
        end
        if (e >= 255) return {1'b1, b[63], 8'hFF, 23'd0};
        if (e <= 0)   return {1'b1, b[63], 31'd0};
        return {g || st, b[63], e[7:0], k[22:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] a, b, c, d,
                        input logic [31:0] eb, input logic ei, input string tag);
        exp_t it;
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; op_d = d;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        it.bits = eb; it.inex = ei; it.tag = tag;
        exp_q.push_back(it);
        n_pushed++;
    endtask

    task automatic send_ref(input logic [31:0] a, b, c, d, input string tag);
        logic [32:0] r;
        r = to_single(to_real(a) * to_real(b) + to_real(c) * to_real(d));
        send(a, b, c, d, r[31:0], r[32], tag);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] rnd_op();
        logic [31:0] r;
        r = $urandom;
        return {r[31], 8'(123 + (r[23:20] % 9)), r[14:0], 8'h00};
    endfunction

    // monitor: scoreboard comparison and handshake timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_acc)
                check(!in_ready, "R2", "ready after accept", 32'(in_ready), 32'd0);
            prev_acc = in_valid && in_ready;
            if (out_valid) begin
                n_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected result", out_result, 32'd0);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    check(out_result == it.bits, it.tag, "result", out_result, it.bits);
                    check(out_inexact == it.inex, it.tag, "inexact",
                          32'(out_inexact), 32'(it.inex));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            n_chk++;
            $display("FAIL R2 watchdog: actual %0d cycles expected under 100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(!out_valid && out_result == 32'd0 && !out_inexact && in_ready,
              "R1", "reset state", out_result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && out_result == 32'd0 && in_ready,
              "R1", "after release", out_result, 32'd0);

        // back-to-back directed set: each accept overlaps the previous strobe
        send(32'h40000000, 32'h40400000, 32'h3F800000, 32'h3F800000, 32'h40E00000, 1'b0, "R7");
        send(32'h3F800000, 32'h40000000, 32'hBF800000, 32'h40400000, 32'hBF800000, 1'b0, "R4");
        send(32'h40000000, 32'h40400000, 32'hC0000000, 32'h40400000, 32'h00000000, 1'b0, "R5");
        send(32'h3F800001, 32'h3FC00000, 32'h00000000, 32'h00000000, 32'h3FC00002, 1'b1, "R6");
        send(32'h7F000000, 32'h7F000000, 32'h00000000, 32'h00000000, 32'h7F800000, 1'b1, "R8");
        send(32'h8D800000, 32'h0D800000, 32'h00000000, 32'h00000000, 32'h80000000, 1'b1, "R9");
        send(32'h7FC12345, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h7FC00000, 1'b0, "R10");
        send(32'h7F800000, 32'h00000000, 32'h3F800000, 32'h3F800000, 32'h7FC00000, 1'b0, "R10");
        send(32'h7F800000, 32'h3F800000, 32'h7F800000, 32'hBF800000, 32'h7FC00000, 1'b0, "R10");
        send(32'hFF800000, 32'h40000000, 32'h3F800000, 32'h3F800000, 32'hFF800000, 1'b0, "R11");
        send(32'h00000001, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, "R12");
        send(32'h40400000, 32'h3F800000, 32'hBFA00000, 32'h3F800000, 32'h3FE00000, 1'b0, "R13");
        send_ref(32'h3F800000, 32'h3F800000, 32'h30800000, 32'h3F800000, "R13");
        send_ref(32'h3FAAAAAB, 32'h40400000, 32'hBF800001, 32'h40800000, "R4");
        send_ref(32'h3FFFFFFF, 32'h3FFFFFFF, 32'h3F800001, 32'h40400001, "R3");
        go_idle();
        repeat (3) @(negedge clk);

        // random operands on the fused path
        for (int i = 0; i < 40; i++) begin
            send_ref(rnd_op(), rnd_op(), rnd_op(), rnd_op(), "R3");
            if (i % 7 == 3) go_idle();
        end
        go_idle();
        repeat (6) @(negedge clk);

        check(n_seen == n_pushed && exp_q.size() == 0, "R2", "result count",
              32'(n_seen), 32'(n_pushed));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule